// File: doc/BRIEF.md
# Indirect Register Window for a Serial Channel

This block is the host-facing register access logic of one channel in a two-channel serial communications controller. The host issues single-byte reads and writes on either a control port or a data port, chosen by a select input. Register 0 on the control port holds a small pointer. When the host writes register 0, the pointer is loaded and, optionally, a command is issued. The next control access then reaches the register that the pointer names, and the pointer falls back to zero afterwards.

A one-shot upper-bank command reaches registers 8 to 15. With this command the next control access goes to the pointer value plus 8. That single access uses the command up. The block holds the write register file and exposes it on a flat output bus.

Read accesses return one of the following: the two status images, the receive byte, or mirrors of write registers. Whether a register mirrors a write register or shows a status image depends on a mirror-enable bit. Write register 9 carries a reset command. The block turns it into one-cycle reset pulses for channel A, channel B or the whole device. The serializers, baud generation, clock recovery, CRC and interrupt chaining all sit outside this block.

Top module: `ser_regwin`

## Requirements
- R1: The `sel_data` input set to 0 selects the control port and set to 1 selects the data port. A data-port write gives a one-cycle `tx_load` pulse with `tx_data` equal to the written byte. A data-port read returns `rx_data`. Neither kind of data access changes the pending pointer.
- R2: The pointer is 0 after reset. When the pointer is 0, a control write loads bits 2:0 of the byte as the pointer. The next control access then reaches register number equal to that pointer. After any control access to a nonzero register, the pointer returns to 0.
- R3: In a control write at pointer 0, a value of 001 in bits 5:3 is the upper-bank command. The next control access then reaches register (bits 2:0) + 8. This holds for that one access only, after which register 0 is selected again.
- R4: A control read at a nonzero register uses up the pointer exactly as a write does. A control read of register 0 returns `stat0`, and a control read of register 1 returns `stat1`.
- R5: A control read of register 4 returns write register 4 when bit 6 of write register 7 is 1, and `stat0` otherwise. A control read of register 5 returns write register 5 when that bit is 1, and `stat1` otherwise.
- R6: Register 8 is an alias of the data port. A control write to register 8 pulses `tx_load` with that byte. A control read of register 8 returns `rx_data`.
- R7: A control read of register 13 returns the last byte written to write register 13. A control read of register 10 returns 0x00.
- R8: Bits 7:6 of a write to register 9 are a reset code: 00 means none, 01 means channel B, 10 means channel A, and 11 means the whole device. In the cycle after the access, the matching output among `ch_b_rst`, `ch_a_rst` and `dev_rst` is high for exactly one cycle. At most one of them is high at any time.
- R9: Write registers 1 to 7 and 9 to 15 keep the written byte verbatim. Register n sits at `wr_file[8n+7:8n]`. Slots 0 and 8 read as zero. The `dpll_cmd` output equals bits 7:5 of write register 14, where 000 is the null command.
- R10: A control read of register 2, 3, 6, 7, 9, 11, 12, 14 or 15 returns 0x00 and sets `bad_acc`. Once set, `bad_acc` stays high until `rst`.
- R11: `rdata` and `rd_valid` are registered. `rd_valid` is high in the cycle after a read access, and only then. `rdata` holds the byte read from then on.
- R12: Synchronous active-high `rst` clears the pointer, the upper-bank flag, every write register, `bad_acc` and all pulse and data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| sel_data | input | 1 | 0 = control port, 1 = data port |
| wdata | input | 8 | Write byte |
| rx_data | input | 8 | Receive byte from the receiver |
| stat0 | input | 8 | Primary status image |
| stat1 | input | 8 | Secondary status image |
| rdata | output | 8 | Registered read byte |
| rd_valid | output | 1 | Read result valid |
| tx_load | output | 1 | Transmit buffer load pulse |
| tx_data | output | 8 | Transmit byte |
| ch_a_rst | output | 1 | Channel A reset pulse |
| ch_b_rst | output | 1 | Channel B reset pulse |
| dev_rst | output | 1 | Device reset pulse |
| bad_acc | output | 1 | Sticky unsupported-read flag |
| dpll_cmd | output | 3 | Clock-recovery command field of register 14 |
| wr_file | output | 128 | All write registers, register n at byte n |

## Verification
The bench writes a distinct, arithmetically generated byte to every register and reads every register back. A miscoded index, a dropped upper-bank bit or a wrong alias shows up as a value mismatch. Each read is followed by a bare control read, which separates pointer consumption from pointer retention. The mirror registers are read with the enable bit both clear and set, using values chosen so that the status images and the stored bytes differ. Separate patterns mix data-port accesses with a pending pointer or a pending upper-bank command, and all four reset codes are swept to check pulse selection and width.

// File: rtl/ser_regwin_pkg.sv
package ser_regwin_pkg;

  typedef enum logic [1:0] {
    RCMD_NONE = 2'b00,
    RCMD_CHB  = 2'b01,
    RCMD_CHA  = 2'b10,
    RCMD_ALL  = 2'b11
  } rcmd_e;

  // command field inside a register-0 write
  localparam int CMD_LSB = 3;
  localparam int CMD_W   = 3;
  localparam logic [CMD_W-1:0] CMD_UPPER = 3'b001;

  // reset code position inside register 9
  localparam int RCMD_LSB = 6;

  // register numbers with special meaning
  localparam int REG_STAT0   = 0;
  localparam int REG_STAT1   = 1;
  localparam int REG_MIR_A   = 4;
  localparam int REG_MIR_B   = 5;
  localparam int REG_MIR_CTL = 7;
  localparam int MIR_BIT     = 6;
  localparam int REG_ALIAS   = 8;
  localparam int REG_RCMD    = 9;
  localparam int REG_ZERO    = 10;
  localparam int REG_TC_HI   = 13;
  localparam int REG_MISC    = 14;
  localparam int DPLL_LSB    = 5;
  localparam int DPLL_W      = 3;

endpackage

// File: rtl/ser_regwin_ptr.sv
module ser_regwin_ptr
  import ser_regwin_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_acc,
  input  logic             ctl_wr,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic [CMD_W-1:0] cmd_in,
  output logic [PTR_W:0]   idx
);

  logic [PTR_W-1:0] ptr_q;
  logic             hi_q;

  assign idx = {hi_q, ptr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      hi_q  <= 1'b0;
    end else if (ctl_acc) begin
      if (idx != '0) begin
        ptr_q <= '0;
        hi_q  <= 1'b0;
      end else if (ctl_wr) begin
        ptr_q <= ptr_in;
        hi_q  <= (cmd_in == CMD_UPPER);
      end
    end
  end

endmodule

// File: rtl/ser_regwin_wregs.sv
module ser_regwin_wregs
  import ser_regwin_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] file
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0 || i == REG_ALIAS) begin : g_none
      assign file[i*DW +: DW] = '0;
    end else begin : g_keep
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (we && widx == IDX_W'(i))
          q <= wdata;
      end
      assign file[i*DW +: DW] = q;
    end
  end

endmodule

// File: rtl/ser_regwin_rdmux.sv
module ser_regwin_rdmux
  import ser_regwin_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    stat0,
  input  logic [DW-1:0]    stat1,
  input  logic [DW-1:0]    rx_data,
  input  logic [DW-1:0]    mir_a,
  input  logic [DW-1:0]    mir_b,
  input  logic             mir_en,
  input  logic [DW-1:0]    tc_hi,
  output logic [DW-1:0]    dout,
  output logic             bad
);

  always_comb begin
    dout = '0;
    bad  = 1'b0;
    case (int'(idx))
      REG_STAT0: dout = stat0;
      REG_STAT1: dout = stat1;
      REG_MIR_A: dout = mir_en ? mir_a : stat0;
      REG_MIR_B: dout = mir_en ? mir_b : stat1;
      REG_ALIAS: dout = rx_data;
      REG_ZERO:  dout = '0;
      REG_TC_HI: dout = tc_hi;
      default:   bad  = 1'b1;
    endcase
  end

endmodule

// File: rtl/ser_regwin_rstcmd.sv
module ser_regwin_rstcmd
  import ser_regwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic [1:0] code,
  output logic       ch_a_rst,
  output logic       ch_b_rst,
  output logic       dev_rst
);

  rcmd_e cmd;
  assign cmd = rcmd_e'(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_a_rst <= 1'b0;
      ch_b_rst <= 1'b0;
      dev_rst  <= 1'b0;
    end else begin
      ch_a_rst <= fire && (cmd == RCMD_CHA);
      ch_b_rst <= fire && (cmd == RCMD_CHB);
      dev_rst  <= fire && (cmd == RCMD_ALL);
    end
  end

endmodule

// File: rtl/ser_regwin.sv
module ser_regwin
  import ser_regwin_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic               sel_data,
  input  logic [DW-1:0]      wdata,
  input  logic [DW-1:0]      rx_data,
  input  logic [DW-1:0]      stat0,
  input  logic [DW-1:0]      stat1,
  output logic [DW-1:0]      rdata,
  output logic               rd_valid,
  output logic               tx_load,
  output logic [DW-1:0]      tx_data,
  output logic               ch_a_rst,
  output logic               ch_b_rst,
  output logic               dev_rst,
  output logic               bad_acc,
  output logic [DPLL_W-1:0]  dpll_cmd,
  output logic [NREG*DW-1:0] wr_file
);

  localparam int IDX_W = $clog2(NREG);
  localparam int PTR_W = IDX_W - 1;

  logic             ctl_acc, ctl_wr, ctl_rd, data_wr, is_rd;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    mux_data, rd_next;
  logic             mux_bad;

  assign ctl_acc = acc_en && !sel_data;
  assign ctl_wr  = ctl_acc && acc_wr;
  assign ctl_rd  = ctl_acc && !acc_wr;
  assign data_wr = acc_en && sel_data && acc_wr;
  assign is_rd   = acc_en && !acc_wr;

  ser_regwin_ptr #(.PTR_W(PTR_W)) ptr_i (
    .clk     (clk),
    .rst     (rst),
    .ctl_acc (ctl_acc),
    .ctl_wr  (ctl_wr),
    .ptr_in  (wdata[PTR_W-1:0]),
    .cmd_in  (wdata[CMD_LSB +: CMD_W]),
    .idx     (idx)
  );

  ser_regwin_wregs #(.DW(DW), .NREG(NREG)) wregs_i (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_wr && idx != '0),
    .widx  (idx),
    .wdata (wdata),
    .file  (wr_file)
  );

  ser_regwin_rdmux #(.DW(DW), .IDX_W(IDX_W)) rdmux_i (
    .idx     (idx),
    .stat0   (stat0),
    .stat1   (stat1),
    .rx_data (rx_data),
    .mir_a   (wr_file[REG_MIR_A*DW +: DW]),
    .mir_b   (wr_file[REG_MIR_B*DW +: DW]),
    .mir_en  (wr_file[REG_MIR_CTL*DW + MIR_BIT]),
    .tc_hi   (wr_file[REG_TC_HI*DW +: DW]),
    .dout    (mux_data),
    .bad     (mux_bad)
  );

  ser_regwin_rstcmd rstcmd_i (
    .clk      (clk),
    .rst      (rst),
    .fire     (ctl_wr && idx == IDX_W'(REG_RCMD)),
    .code     (wdata[RCMD_LSB +: 2]),
    .ch_a_rst (ch_a_rst),
    .ch_b_rst (ch_b_rst),
    .dev_rst  (dev_rst)
  );

  assign rd_next  = sel_data ? rx_data : mux_data;
  assign dpll_cmd = wr_file[REG_MISC*DW + DPLL_LSB +: DPLL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      tx_load  <= 1'b0;
      tx_data  <= '0;
      bad_acc  <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd)
        rdata <= rd_next;
      tx_load <= data_wr || (ctl_wr && idx == IDX_W'(REG_ALIAS));
      if (data_wr || (ctl_wr && idx == IDX_W'(REG_ALIAS)))
        tx_data <= wdata;
      if (ctl_rd && mux_bad)
        bad_acc <= 1'b1;
    end
  end

endmodule

// File: rtl/ser_regwin_chk.sv
module ser_regwin_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic             acc_wr,
  input logic             sel_data,
  input logic [IDX_W-1:0] idx,
  input logic             tx_load,
  input logic             rd_valid,
  input logic             bad_acc,
  input logic             ch_a_rst,
  input logic             ch_b_rst,
  input logic             dev_rst
);

  // R2
  ptr_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !sel_data && idx != '0) |=> (idx == '0));

  // R1
  data_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && sel_data) |=> $stable(idx));

  // R8
  rst_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ch_a_rst, ch_b_rst, dev_rst}));

  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_a_rst || ch_b_rst || dev_rst) |=> !(ch_a_rst || ch_b_rst || dev_rst));

  // R10
  bad_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bad_acc |=> bad_acc);

  // R11
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_en && !acc_wr));

  // R1
  tx_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(acc_en && acc_wr));

endmodule

bind ser_regwin ser_regwin_chk #(.IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .acc_en   (acc_en),
  .acc_wr   (acc_wr),
  .sel_data (sel_data),
  .idx      (idx),
  .tx_load  (tx_load),
  .rd_valid (rd_valid),
  .bad_acc  (bad_acc),
  .ch_a_rst (ch_a_rst),
  .ch_b_rst (ch_b_rst),
  .dev_rst  (dev_rst)
);

// File: tb/ser_regwin_tb_top.sv
`timescale 1ns/1ps
module ser_regwin_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ST0 = 8'hA5;
  localparam logic [7:0] ST1 = 8'h3C;
  localparam logic [7:0] RXB = 8'h6E;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         acc_en = 1'b0, acc_wr = 1'b0, sel_data = 1'b0;
  logic [7:0]   wdata = 8'h00;
  logic [7:0]   rx_data = RXB, stat0 = ST0, stat1 = ST1;
  logic [7:0]   rdata, tx_data;
  logic         rd_valid, tx_load, ch_a_rst, ch_b_rst, dev_rst, bad_acc;
  logic [2:0]   dpll_cmd;
  logic [127:0] wr_file;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] mw [16];
  logic       bad_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_regwin dut_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .sel_data(sel_data),
    .wdata(wdata), .rx_data(rx_data), .stat0(stat0), .stat1(stat1),
    .rdata(rdata), .rd_valid(rd_valid), .tx_load(tx_load), .tx_data(tx_data),
    .ch_a_rst(ch_a_rst), .ch_b_rst(ch_b_rst), .dev_rst(dev_rst),
    .bad_acc(bad_acc), .dpll_cmd(dpll_cmd), .wr_file(wr_file)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one access; returns at the falling edge after the capturing edge
  task automatic acc(input logic wr, input logic sel, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; sel_data = sel; wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; sel_data = 1'b0; wdata = 8'h00;
  endtask

  task automatic point(input int r);
    if (r >= 8) acc(1'b1, 1'b0, 8'h08 | 8'(r & 7));
    else if (r != 0) acc(1'b1, 1'b0, 8'(r));
  endtask

  function automatic logic [7:0] val(input int r);
    logic [7:0] v;
    v = 8'((r * 29 + 8'h47) & 8'hFF);
    if (r == 9) v = v & 8'h3F;
    return v;
  endfunction

  function automatic bit supported(input int r);
    return (r == 0 || r == 1 || r == 4 || r == 5 || r == 8 || r == 10 || r == 13);
  endfunction

  function automatic logic [7:0] exp_rd(input int r);
    logic mir;
    mir = mw[7][6];
    case (r)
      0:  return ST0;
      1:  return ST1;
      4:  return mir ? mw[4] : ST0;
      5:  return mir ? mw[5] : ST1;
      8:  return RXB;
      13: return mw[13];
      default: return 8'h00;
    endcase
  endfunction

  task automatic read_chk(input int r, input string tag);
    point(r);
    acc(1'b0, 1'b0, 8'h00);
    chk({tag, " rd_valid"}, rd_valid, 1'b1);
    chk({tag, " rdata"}, rdata, exp_rd(r));
    if (!supported(r)) bad_exp = 1'b1;
    chk({tag, " bad_acc R10"}, bad_acc, bad_exp);
    // pointer must be back at register 0
    acc(1'b0, 1'b0, 8'h00);
    chk({tag, " ptr back R2 R4"}, rdata, ST0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mw[i] = 8'h00;
    bad_exp = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 wr_file", wr_file, '0);
    chk("R12 rd_valid", rd_valid, 1'b0);
    chk("R12 tx_load", tx_load, 1'b0);
    chk("R12 bad_acc", bad_acc, 1'b0);
    chk("R12 rdata", rdata, 8'h00);

    // R9 write sweep (R3 for upper registers), R8 code 00 gives no pulse
    for (int r = 1; r < 16; r++) begin
      if (r == 8) continue;
      point(r);
      acc(1'b1, 1'b0, val(r));
      mw[r] = val(r);
      chk($sformatf("R9 slot %0d", r), wr_file[r*8 +: 8], val(r));
      chk($sformatf("R8 no pulse reg %0d", r), {ch_a_rst, ch_b_rst, dev_rst}, 3'b000);
    end
    chk("R9 slot0", wr_file[7:0], 8'h00);
    chk("R9 dpll_cmd", dpll_cmd, val(14) >> 5);

    // R6 control write through alias
    point(8);
    acc(1'b1, 1'b0, 8'h5B);
    chk("R6 tx_load", tx_load, 1'b1);
    chk("R6 tx_data", tx_data, 8'h5B);
    chk("R6 slot8", wr_file[64 +: 8], 8'h00);
    @(negedge clk);
    chk("R6 tx_load width", tx_load, 1'b0);

    // read sweep: supported first (R4 R5 R6 R7), then the rest (R10)
    for (int r = 0; r < 16; r++)
      if (supported(r)) read_chk(r, $sformatf("R5 R7 read %0d", r));
    for (int r = 0; r < 16; r++)
      if (!supported(r)) read_chk(r, $sformatf("R10 read %0d", r));

    // R5 mirror enabled
    point(7);
    acc(1'b1, 1'b0, val(7) | 8'h40);
    mw[7] = val(7) | 8'h40;
    read_chk(4, "R5 mirror 4");
    read_chk(5, "R5 mirror 5");

    // R3 upper bank lasts one access
    acc(1'b1, 1'b0, 8'h0D);
    acc(1'b0, 1'b0, 8'h00);
    chk("R3 reg13", rdata, mw[13]);
    acc(1'b0, 1'b0, 8'h00);
    chk("R3 lapse", rdata, ST0);

    // R1 data write with upper bank pending does not consume it
    acc(1'b1, 1'b0, 8'h08);
    acc(1'b1, 1'b1, 8'h77);
    chk("R1 data tx_load", tx_load, 1'b1);
    chk("R1 data tx_data", tx_data, 8'h77);
    acc(1'b0, 1'b0, 8'h00);
    chk("R1 R3 pending alias read", rdata, RXB);
    acc(1'b0, 1'b0, 8'h00);
    chk("R1 after alias", rdata, ST0);

    // R1 data read with pointer pending
    acc(1'b1, 1'b0, 8'h01);
    acc(1'b0, 1'b1, 8'h00);
    chk("R1 data read", rdata, RXB);
    chk("R11 rd_valid", rd_valid, 1'b1);
    @(negedge clk);
    chk("R11 rd_valid drop", rd_valid, 1'b0);
    chk("R11 rdata hold", rdata, RXB);
    acc(1'b0, 1'b0, 8'h00);
    chk("R1 ptr kept", rdata, ST1);

    // R8 reset code sweep
    for (int c = 0; c < 4; c++) begin
      logic [2:0] e;
      e = (c == 1) ? 3'b010 : (c == 2) ? 3'b100 : (c == 3) ? 3'b001 : 3'b000;
      point(9);
      acc(1'b1, 1'b0, 8'(c << 6) | 8'h05);
      chk($sformatf("R8 code %0d", c), {ch_a_rst, ch_b_rst, dev_rst}, e);
      @(negedge clk);
      chk($sformatf("R8 width %0d", c), {ch_a_rst, ch_b_rst, dev_rst}, 3'b000);
      acc(1'b0, 1'b0, 8'h00);
      chk($sformatf("R8 ptr clear %0d", c), rdata, ST0);
    end

    // R12 reset clears pending pointer, registers and flag
    acc(1'b1, 1'b0, 8'h03);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R12 wr_file after rst", wr_file, '0);
    chk("R12 R10 bad cleared", bad_acc, 1'b0);
    acc(1'b0, 1'b0, 8'h00);
    chk("R12 ptr cleared", rdata, ST0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule